// File: doc/BRIEF.md
# Token-Triggered Neighbour Duplicate-Compare Array

This block is a one-way linear pipeline of identical processing elements in which every element keeps a running state and passes its result to the element on its right. It has concurrent error detection built in and no spare element. A caller may place a test token into the input slot stream in any cycle. The token then advances through the array, one element per cycle, in the same way as a data item.

When element j (j ≥ 1) holds the token and element j-1 holds a data item, element j borrows the operands of j-1 (its held data, its incoming carry and its state) and repeats that computation. It then compares its result with the result produced by j-1 in the same cycle. A difference sets a sticky error flag and records the lowest failing element index. Element j leaves its own state untouched while it holds the token, so the data behind the token sees exactly the state it would have seen without the token, one cycle later. The caller therefore chooses how often to test by choosing how many token slots to spend.

Each element computes `r = (rotl1(s) + d) ^ c`, where `s` is its state, `d` is the data item and `c` is the carry, which is the result of the element to its left (0 for element 0). A fault input flips bit 0 of the result of one selected element, so that the detection path can be exercised.

Top module: `tdc_array`

## Requirements
- R1: A token takes one input slot and advances exactly one element per cycle. It never reaches `out_data`. A data item accepted at a clock edge appears with `out_valid` high N edges later, and items leave in input order.
- R2: With no tokens, each output equals the reference chain: element i computes `r_i = (rotl1(s_i) + d) ^ r_{i-1}` with `r_{-1} = 0`, stores `r_i` as its new state, and `out_data` is `r_{N-1}`.
- R3: An element that holds a token does not change its state.
- R4: A token at element j ≥ 1, with a data item at element j-1 in the same cycle, raises `err_flag` if the duplicated result differs from the result of j-1. `err_idx` then names the checking element j.
- R5: No comparison takes place unless the token's left neighbour holds a data item. Without tokens, or when the slot in front of the data item is empty, a fault raises no error.
- R6: Element 0 performs no comparison. A fault in element 0 is reported by the pair checked at element 1, so `err_idx` is 1.
- R7: `err_flag` stays set until `err_clr` is high. A clear resets the flag and `err_idx` to 0 on the next edge and takes priority over a mismatch in the same cycle.
- R8: `err_idx` holds the lowest failing index seen since the last clear. A later mismatch at a higher index leaves it unchanged, and one at a lower index replaces it.
- R9: With `fault_en` high, the result of element `fault_sel` has bit 0 inverted.
- R10: Under reset, `out_valid`, `err_flag`, `err_idx` and all states are 0.
- R11: Inserting tokens anywhere in a stream leaves the sequence of output data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Data slot this cycle |
| in_tok | input | 1 | Token slot this cycle; takes priority over `in_valid`, and `in_data` is ignored |
| in_data | input | W | Data item |
| err_clr | input | 1 | Clears the sticky error |
| fault_en | input | 1 | Enables fault injection |
| fault_sel | input | IW | Element whose result is corrupted |
| out_valid | output | 1 | `out_data` holds a result |
| out_data | output | W | Result of the last element |
| err_flag | output | 1 | Sticky mismatch flag |
| err_idx | output | IW | Lowest element index that saw a mismatch |

## Verification
A random mix of data, empty and token slots is compared with a bench model that never sees tokens. Any lost, repeated or reordered item, or any state that a token corrupted, shows up as a difference from that model. Directed runs with fault injection separate four cases:
- a fault with no token present, which must stay silent;
- a token followed by its data item, which must report the faulty pair;
- a token followed by an empty slot, which must not compare;
- faults at either end of the array, which show where element 0 has no neighbour.

Changing the faulty element between tokens, without clearing, shows whether the lowest-index rule is kept.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_DATA  = 2'd1,
    SLOT_TOKEN = 2'd2
  } slot_e;
endpackage

// File: rtl/tdc_cell.sv
module tdc_cell
  import tdc_pkg::*;
#(
  parameter int W        = 16,
  parameter int HAS_LEFT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  slot_e        ld_kind,
  input  logic [W-1:0] ld_d,
  input  logic [W-1:0] ld_c,
  input  slot_e        nb_kind,
  input  logic [W-1:0] nb_d,
  input  logic [W-1:0] nb_c,
  input  logic [W-1:0] nb_s,
  input  logic [W-1:0] nb_res,
  input  logic         fault,
  output slot_e        kind_q,
  output logic [W-1:0] d_q,
  output logic [W-1:0] c_q,
  output logic [W-1:0] st_q,
  output logic [W-1:0] res,
  output logic         mism
);
  // element operation: rotate state left by one, add data, xor carry
  function automatic logic [W-1:0] step_fn(input logic [W-1:0] s, input logic [W-1:0] d,
                                           input logic [W-1:0] c);
    logic [W-1:0] rot;
    rot = {s[W-2:0], s[W-1]};
    return (rot + d) ^ c;
  endfunction

  logic         dup;
  logic [W-1:0] op_s, op_d, op_c;

  assign dup  = (kind_q == SLOT_TOKEN);
  assign op_s = dup ? nb_s : st_q;
  assign op_d = dup ? nb_d : d_q;
  assign op_c = dup ? nb_c : c_q;
  assign res  = step_fn(op_s, op_d, op_c) ^ {{(W-1){1'b0}}, fault};
  assign mism = (HAS_LEFT != 0) && dup && (nb_kind == SLOT_DATA) && (res != nb_res);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= SLOT_EMPTY;
      d_q    <= '0;
      c_q    <= '0;
      st_q   <= '0;
    end else begin
      kind_q <= ld_kind;
      d_q    <= ld_d;
      c_q    <= ld_c;
      if (kind_q == SLOT_DATA) st_q <= res;
    end
  end
endmodule

// File: rtl/tdc_err_track.sv
module tdc_err_track #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  mism,
  input  logic          clr,
  output logic          flag,
  output logic [IW-1:0] idx
);
  function automatic logic [IW-1:0] lowest(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int k = N - 1; k >= 0; k--) if (v[k]) r = IW'(k);
    return r;
  endfunction

  logic [IW-1:0] lo;
  assign lo = lowest(mism);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      flag <= 1'b0;
      idx  <= '0;
    end else if (|mism) begin
      flag <= 1'b1;
      if (!flag || lo < idx) idx <= lo;
    end
  end
endmodule

// File: rtl/tdc_array.sv
module tdc_array
  import tdc_pkg::*;
#(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_tok,
  input  logic [W-1:0]  in_data,
  input  logic          err_clr,
  input  logic          fault_en,
  input  logic [IW-1:0] fault_sel,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic          err_flag,
  output logic [IW-1:0] err_idx
);
  localparam int LAST = N - 1;

  slot_e        kind_w [N];
  logic [W-1:0] d_w    [N];
  logic [W-1:0] c_w    [N];
  logic [W-1:0] st_w   [N];
  logic [W-1:0] res_w  [N];

  // named event wires for the checker
  logic [N-1:0]   mism_vec;
  logic [N-1:0]   tok_vec;
  logic [N-1:0]   dat_vec;
  logic [N*W-1:0] st_flat;

  for (genvar i = 0; i < N; i++) begin : g_pe
    slot_e        ld_kind, nb_kind;
    logic [W-1:0] ld_d, ld_c, nb_d, nb_c, nb_s, nb_res;

    if (i == 0) begin : g_head
      assign ld_kind = in_tok ? SLOT_TOKEN : (in_valid ? SLOT_DATA : SLOT_EMPTY);
      assign ld_d    = in_tok ? '0 : in_data;
      assign ld_c    = '0;
      assign nb_kind = SLOT_EMPTY;
      assign nb_d    = '0;
      assign nb_c    = '0;
      assign nb_s    = '0;
      assign nb_res  = '0;
    end else begin : g_body
      assign ld_kind = kind_w[i-1];
      assign ld_d    = d_w[i-1];
      assign ld_c    = (kind_w[i-1] == SLOT_DATA) ? res_w[i-1] : '0;
      assign nb_kind = kind_w[i-1];
      assign nb_d    = d_w[i-1];
      assign nb_c    = c_w[i-1];
      assign nb_s    = st_w[i-1];
      assign nb_res  = res_w[i-1];
    end

    tdc_cell #(.W(W), .HAS_LEFT((i == 0) ? 0 : 1)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_kind(ld_kind),
      .ld_d   (ld_d),
      .ld_c   (ld_c),
      .nb_kind(nb_kind),
      .nb_d   (nb_d),
      .nb_c   (nb_c),
      .nb_s   (nb_s),
      .nb_res (nb_res),
      .fault  (fault_en && (fault_sel == IW'(i))),
      .kind_q (kind_w[i]),
      .d_q    (d_w[i]),
      .c_q    (c_w[i]),
      .st_q   (st_w[i]),
      .res    (res_w[i]),
      .mism   (mism_vec[i])
    );

    assign tok_vec[i]          = (kind_w[i] == SLOT_TOKEN);
    assign dat_vec[i]          = (kind_w[i] == SLOT_DATA);
    assign st_flat[i*W +: W]   = st_w[i];
  end

  tdc_err_track #(.N(N), .IW(IW)) u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .mism (mism_vec),
    .clr  (err_clr),
    .flag (err_flag),
    .idx  (err_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= dat_vec[LAST];
      out_data  <= res_w[LAST];
    end
  end
endmodule

// File: rtl/tdc_array_chk.sv
module tdc_array_chk #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int IW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   tok_vec,
  input logic [N-1:0]   dat_vec,
  input logic [N-1:0]   mism_vec,
  input logic [N*W-1:0] st_flat,
  input logic           err_clr,
  input logic           err_flag,
  input logic [IW-1:0]  err_idx
);
  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_STATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      tok_vec[i] |=> $stable(st_flat[i*W +: W])); // R3
    if (i < N - 1) begin : g_adv
      AST_TOKEN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        tok_vec[i] |=> tok_vec[i+1]); // R1
    end
    if (i > 0) begin : g_cmp
      AST_COMPARE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        mism_vec[i] |-> (tok_vec[i] && dat_vec[i-1])); // R5
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag); // R7
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (!err_flag && err_idx == '0)); // R7
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> ($past(mism_vec) != '0)); // R4
  AST_IDX_NOT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> (err_idx != '0)); // R6
endmodule

bind tdc_array tdc_array_chk #(.N(N), .W(W), .IW(IW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tok_vec (tok_vec),
  .dat_vec (dat_vec),
  .mism_vec(mism_vec),
  .st_flat (st_flat),
  .err_clr (err_clr),
  .err_flag(err_flag),
  .err_idx (err_idx)
);

// File: tb/tb_tdc_array.sv
`timescale 1ns/1ps
module tb_tdc_array;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int IW = 3;
  localparam int QD = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_tok = 1'b0, err_clr = 1'b0, fault_en = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic [IW-1:0] fault_sel = '0;
  logic          out_valid, err_flag;
  logic [W-1:0]  out_data;
  logic [IW-1:0] err_idx;

  tdc_array #(.N(N), .W(W), .IW(IW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tok(in_tok), .in_data(in_data),
    .err_clr(err_clr), .fault_en(fault_en), .fault_sel(fault_sel),
    .out_valid(out_valid), .out_data(out_data), .err_flag(err_flag), .err_idx(err_idx)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, ne = 0, ng = 0;
  bit finished = 0;
  logic [W-1:0] exp_q [QD];
  logic [W-1:0] got_q [QD];
  logic [W-1:0] rs [N];

  function automatic logic [W-1:0] ref_step(input logic [W-1:0] s, input logic [W-1:0] d,
                                            input logic [W-1:0] c);
    logic [W-1:0] r;
    r = (s << 1) | (s >> (W - 1));
    r = r + d;
    return r ^ c;
  endfunction

  task automatic ref_push(input logic [W-1:0] d);
    logic [W-1:0] c;
    c = '0;
    for (int i = 0; i < N; i++) begin
      rs[i] = ref_step(rs[i], d, c);
      c = rs[i];
    end
    if (ne < QD) exp_q[ne] = c;
    ne++;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (ng < QD) got_q[ng] = out_data;
      ng++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic slot_data(input logic [W-1:0] d);
    @(negedge clk); in_valid = 1'b1; in_tok = 1'b0; in_data = d; ref_push(d);
  endtask
  task automatic slot_tok();
    @(negedge clk); in_valid = 1'b1; in_tok = 1'b1; in_data = 16'hBEEF;
  endtask
  task automatic slot_idle();
    @(negedge clk); in_valid = 1'b0; in_tok = 1'b0; in_data = '0;
  endtask
  task automatic drain();
    for (int k = 0; k < N + 3; k++) slot_idle();
  endtask
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 0; in_tok = 0; err_clr = 0; fault_en = 0;
    for (int i = 0; i < N; i++) rs[i] = '0;
    ne = 0; ng = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask
  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask
  task automatic cmp_stream(input string tag);
    chk({tag, " count"}, 32'(ng), 32'(ne));
    for (int k = 0; k < ne && k < QD; k++) chk(tag, 32'(got_q[k]), 32'(exp_q[k]));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat;
    void'($urandom(32'h5EED1234));
    do_reset();
    // R10 reset state
    chk("R10 out_valid", 32'(out_valid), 0);
    chk("R10 err_flag", 32'(err_flag), 0);
    chk("R10 err_idx", 32'(err_idx), 0);

    // R1 latency: item appears N edges after acceptance
    slot_data(16'h0123);
    lat = 0;
    for (int c = 1; c <= N + 3; c++) begin
      @(negedge clk); in_valid = 1'b0;
      if (out_valid && lat == 0) lat = c;
    end
    chk("R1 latency", 32'(lat), 32'(N + 1));

    // R2 plain stream, no tokens
    for (int k = 0; k < 20; k++) slot_data(16'($urandom));
    drain();
    cmp_stream("R2 no-token stream");

    // R11 / R3 token before every item
    do_reset();
    for (int k = 0; k < 30; k++) begin slot_tok(); slot_data(16'($urandom)); end
    drain();
    cmp_stream("R11 token-every-item stream");
    chk("R4 no false error", 32'(err_flag), 0);

    // R11 random mix
    do_reset();
    for (int k = 0; k < 400; k++) begin
      int r;
      r = int'($urandom % 8);
      if (r < 2) slot_tok();
      else if (r == 2) slot_idle();
      else slot_data(16'($urandom));
    end
    drain();
    cmp_stream("R11 random mix");
    chk("R4 random no false error", 32'(err_flag), 0);

    // R9 fault flips bit 0 of the last element
    do_reset();
    @(negedge clk); fault_en = 1'b1; fault_sel = IW'(N - 1);
    slot_data(16'h4321);
    drain();
    chk("R9 fault count", 32'(ng), 1);
    chk("R9 fault flip", 32'(got_q[0]), 32'(exp_q[0] ^ 16'h0001));

    // R5 fault without tokens stays silent
    do_reset();
    @(negedge clk); fault_en = 1'b1; fault_sel = 3'd3;
    for (int k = 0; k < 10; k++) slot_data(16'($urandom));
    drain();
    chk("R5 no token no error", 32'(err_flag), 0);
    // R5 token followed by an empty slot: no compare
    slot_tok(); slot_idle(); slot_data(16'h1111);
    drain();
    chk("R5 gap no error", 32'(err_flag), 0);
    // R4 token with data behind it detects the fault
    slot_tok(); slot_data(16'h2222);
    drain();
    chk("R4 detect flag", 32'(err_flag), 1);
    chk("R4 detect idx", 32'(err_idx), 3);
    drain();
    chk("R7 sticky flag", 32'(err_flag), 1);
    chk("R8 lowest kept", 32'(err_idx), 3);
    pulse_clr();
    chk("R7 cleared flag", 32'(err_flag), 0);
    chk("R7 cleared idx", 32'(err_idx), 0);
    // R8 higher then lower
    @(negedge clk); fault_sel = 3'd5;
    slot_tok(); slot_data(16'h3333); drain();
    chk("R8 first idx", 32'(err_idx), 5);
    @(negedge clk); fault_sel = 3'd2;
    slot_tok(); slot_data(16'h4444); drain();
    chk("R8 lower replaces", 32'(err_idx), 2);
    @(negedge clk); fault_sel = 3'd6;
    slot_tok(); slot_data(16'h5555); drain();
    chk("R8 higher ignored", 32'(err_idx), 2);
    pulse_clr();
    // R4 boundary: last element
    @(negedge clk); fault_sel = IW'(N - 1);
    slot_tok(); slot_data(16'h6666); drain();
    chk("R4 last idx", 32'(err_idx), 32'(N - 1));

    // R6 fault in element 0 reported at element 1
    do_reset();
    @(negedge clk); fault_en = 1'b1; fault_sel = 3'd0;
    slot_tok(); slot_data(16'h7777); drain();
    chk("R6 head flag", 32'(err_flag), 1);
    chk("R6 head idx", 32'(err_idx), 1);
    @(negedge clk); fault_en = 1'b0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule